// File: doc/BRIEF.md
# Host Port Register Decoder

This block decodes host accesses to the register port of an optical-drive controller running in a compatibility mode. The host side offers an active-low DMA acknowledge, an active-low port enable, a two-bit register address and active-low read and write strobes. The block brings both strobes into the core clock domain and acts once on the falling edge of each. For every access it raises exactly one one-cycle select pulse toward the register it addresses: command-in, status-out, data (register or DMA) or transfer status. A write to the reset register drives a timed low pulse toward the sub-processor.

Two state bits live inside the block: DMA mode and a transfer-hold flag, loaded together from a host-control write. Address 0 changes meaning with them. While a non-DMA data transfer is selected, address 0 carries data. Otherwise a write there reaches the command-in register and a read returns the status-out register. The block also builds the 8-bit transfer status byte. Its wait bit and its DMA-request bit report the same wait source, and the DMA mode bit decides which of the two carries it.

Read data (`host_rdata`) follows the present address and control inputs combinationally. It returns 0xFF when no readable register is addressed.

Top module: `hpr_decode`

## Requirements
- R1: With `dmack_n` low, a write strobe gives a `dma_we` pulse and a read strobe gives a `dma_re` pulse, whatever `hen_n` and `addr` are. `host_rdata` then shows `xfer_rdata`.
- R2: With `dmack_n` and `hen_n` both high, an access gives no pulse and no reset, and `host_rdata` is 0xFF.
- R3: A transfer is selected only when DMA mode is 0, `xfer_en_n` is 0 and the hold flag is 0. Writing address 2 (port enabled, no DMA acknowledge) loads DMA mode from data bit 0 and the hold flag from data bit 1, shown on `dma_mode` and `dts_flag`. Both are 0 after reset.
- R4: At address 0 with no transfer selected, a write gives `cmdin_we` and a read gives `sbout_re`. `host_rdata` then shows `sbout_in`.
- R5: At address 0 with a transfer selected, a write gives `dat_we` and a read gives `dat_re`. `host_rdata` then shows `xfer_rdata`.
- R6: A write to address 1 drives `sub_rst_n` low for RST_CYCLES clocks (default 8) and changes neither `dma_mode` nor `dts_flag`. A further such write during the pulse restarts the count.
- R7: A read at address 1 gives `tstat_re`. `host_rdata` there is {1, 1, eject, WAIT, eop, sten, xfer_en_n, DRQ} from bit 7 down to bit 0.
- R8: In that byte, WAIT (bit 4) equals `wait_src` when DMA mode is 0 and is 1 otherwise. DRQ (bit 0) equals `wait_src` when DMA mode is 1 and is 0 otherwise.
- R9: Address 3, and a read at address 2, give no pulse and no reset, and `host_rdata` is 0xFF.
- R10: Each access gives its pulse once, for one clock. The pulse is seen at the third falling clock edge after the strobe goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dmack_n | input | 1 | DMA acknowledge, active low |
| hen_n | input | 1 | Register port enable, active low |
| addr | input | 2 | Register address |
| hrd_n | input | 1 | Read strobe, active low |
| hwr_n | input | 1 | Write strobe, active low |
| host_wdata | input | 8 | Host write data |
| xfer_en_n | input | 1 | Sub-processor has started a transfer, active low |
| wait_src | input | 1 | Wait source for the status byte |
| eject_in | input | 1 | Eject pin level |
| eop_in | input | 1 | End-of-transfer pin level |
| sten_in | input | 1 | Status-enable pin level |
| sbout_in | input | 8 | Status-out register contents |
| xfer_rdata | input | 8 | Data-path read data |
| host_rdata | output | 8 | Read data toward the host |
| cmdin_we | output | 1 | Command-in write pulse |
| sbout_re | output | 1 | Status-out read pulse |
| dat_we | output | 1 | Register data write pulse |
| dat_re | output | 1 | Register data read pulse |
| dma_we | output | 1 | DMA data write pulse |
| dma_re | output | 1 | DMA data read pulse |
| tstat_re | output | 1 | Transfer status read pulse |
| sub_rst_n | output | 1 | Sub-processor reset, active low |
| dma_mode | output | 1 | Host-control DMA mode bit |
| dts_flag | output | 1 | Host-control transfer-hold bit |

## Verification
The main sweep tries every DMA-acknowledge, enable, address and direction combination under all four host-control settings, each with the transfer-enable input both high and low. Only the three-way transfer-select condition tells command/status accesses apart from data accesses at address 0, so this sweep separates the two meanings of address 0 and shows that DMA acknowledge overrides everything else. A second sweep reads the status byte over all pin combinations in both modes, which tells apart a correct WAIT/DRQ swap from a swapped or stuck bit. Back-to-back reset writes show whether the pulse restarts or simply runs out.

// File: rtl/hpr_decode.sv
module hpr_decode #(
  parameter int RST_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dmack_n,
  input  logic       hen_n,
  input  logic [1:0] addr,
  input  logic       hrd_n,
  input  logic       hwr_n,
  input  logic [7:0] host_wdata,
  input  logic       xfer_en_n,
  input  logic       wait_src,
  input  logic       eject_in,
  input  logic       eop_in,
  input  logic       sten_in,
  input  logic [7:0] sbout_in,
  input  logic [7:0] xfer_rdata,
  output logic [7:0] host_rdata,
  output logic       cmdin_we,
  output logic       sbout_re,
  output logic       dat_we,
  output logic       dat_re,
  output logic       dma_we,
  output logic       dma_re,
  output logic       tstat_re,
  output logic       sub_rst_n,
  output logic       dma_mode,
  output logic       dts_flag
);
  localparam int CW = $clog2(RST_CYCLES + 1);

  logic [2:0] rd_sy, wr_sy;
  logic       rd_fall, wr_fall;
  logic       reg_acc, dma_acc, xfer_sel;
  logic       hit0, hit1, hit2;
  logic       rst_req, hctl_req;
  logic [CW-1:0] rst_cnt;
  logic [7:0] tstat;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_sy <= '1;
      wr_sy <= '1;
    end else begin
      rd_sy <= {rd_sy[1:0], hrd_n};
      wr_sy <= {wr_sy[1:0], hwr_n};
    end

  assign rd_fall  = rd_sy[2] & ~rd_sy[1];
  assign wr_fall  = wr_sy[2] & ~wr_sy[1];

  assign dma_acc  = ~dmack_n;
  assign reg_acc  = dmack_n & ~hen_n;
  assign hit0     = reg_acc & (addr == 2'd0);
  assign hit1     = reg_acc & (addr == 2'd1);
  assign hit2     = reg_acc & (addr == 2'd2);
  assign xfer_sel = ~dma_mode & ~xfer_en_n & ~dts_flag;

  assign rst_req  = wr_fall & hit1;
  assign hctl_req = wr_fall & hit2;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cmdin_we <= 1'b0;
      sbout_re <= 1'b0;
      dat_we   <= 1'b0;
      dat_re   <= 1'b0;
      dma_we   <= 1'b0;
      dma_re   <= 1'b0;
      tstat_re <= 1'b0;
    end else begin
      cmdin_we <= wr_fall & hit0 & ~xfer_sel;
      sbout_re <= rd_fall & hit0 & ~xfer_sel;
      dat_we   <= wr_fall & hit0 & xfer_sel;
      dat_re   <= rd_fall & hit0 & xfer_sel;
      dma_we   <= wr_fall & dma_acc;
      dma_re   <= rd_fall & dma_acc;
      tstat_re <= rd_fall & hit1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dma_mode <= 1'b0;
      dts_flag <= 1'b0;
    end else if (hctl_req) begin
      dma_mode <= host_wdata[0];
      dts_flag <= host_wdata[1];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      rst_cnt <= '0;
    else if (rst_req)
      rst_cnt <= CW'(RST_CYCLES);
    else if (rst_cnt != '0)
      rst_cnt <= rst_cnt - 1'b1;

  assign sub_rst_n = (rst_cnt == '0);

  assign tstat = {2'b11, eject_in, dma_mode | wait_src, eop_in, sten_in,
                  xfer_en_n, dma_mode & wait_src};

  always_comb begin
    host_rdata = 8'hFF;
    if (dma_acc)
      host_rdata = xfer_rdata;
    else if (reg_acc)
      case (addr)
        2'd0:    host_rdata = xfer_sel ? xfer_rdata : sbout_in;
        2'd1:    host_rdata = tstat;
        default: host_rdata = 8'hFF;
      endcase
  end
endmodule

module hpr_decode_chk #(
  parameter int RST_CYCLES = 8
) (
  input logic clk,
  input logic rst_n,
  input logic rst_req,
  input logic cmdin_we,
  input logic sbout_re,
  input logic dat_we,
  input logic dat_re,
  input logic dma_we,
  input logic dma_re,
  input logic tstat_re,
  input logic sub_rst_n,
  input logic dma_mode,
  input logic dts_flag
);
  int lowc;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lowc <= 0;
    else if (rst_req) lowc <= 0;
    else if (!sub_rst_n) lowc <= lowc + 1;

  AST_DMA_OVERRIDES: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_we || dma_re) |-> !(cmdin_we || sbout_re || dat_we || dat_re || tstat_re)); // R1
  AST_ADDR0_ONE_MEANING: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmdin_we, sbout_re, dat_we, dat_re})); // R5
  AST_RST_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    !sub_rst_n |-> (lowc < RST_CYCLES)); // R6
  AST_RST_KEEPS_HCTL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sub_rst_n) |-> ($stable(dma_mode) && $stable(dts_flag))); // R6
  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdin_we || dat_we || dma_we) |=> !(cmdin_we || dat_we || dma_we)); // R10
endmodule

bind hpr_decode hpr_decode_chk #(.RST_CYCLES(RST_CYCLES)) chk_i (
  .clk(clk), .rst_n(rst_n), .rst_req(rst_req),
  .cmdin_we(cmdin_we), .sbout_re(sbout_re), .dat_we(dat_we), .dat_re(dat_re),
  .dma_we(dma_we), .dma_re(dma_re), .tstat_re(tstat_re),
  .sub_rst_n(sub_rst_n), .dma_mode(dma_mode), .dts_flag(dts_flag)
);

// File: tb/hpr_decode_tb.sv
module hpr_decode_tb_top;
  localparam int RSTC = 8;
  logic clk = 0, rst_n = 0;
  logic dmack_n = 1, hen_n = 1, hrd_n = 1, hwr_n = 1;
  logic [1:0] addr = 0;
  logic [7:0] host_wdata = 0, sbout_in = 8'h3C, xfer_rdata = 8'hA5;
  logic xfer_en_n = 1, wait_src = 0, eject_in = 0, eop_in = 0, sten_in = 0;
  logic [7:0] host_rdata;
  logic cmdin_we, sbout_re, dat_we, dat_re, dma_we, dma_re, tstat_re;
  logic sub_rst_n, dma_mode, dts_flag;

  int checks = 0, errors = 0;
  bit done = 0;
  int pc[7];
  int lowcnt, first_idx;
  logic [7:0] rd_s;

  always #10 clk = ~clk;

  hpr_decode #(.RST_CYCLES(RSTC)) dut_i (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input bit dm, input bit hn, input logic [1:0] ad,
                        input bit wr, input logic [7:0] wd);
    logic [6:0] pv;
    @(negedge clk);
    dmack_n = dm; hen_n = hn; addr = ad; host_wdata = wd;
    if (wr) hwr_n = 0; else hrd_n = 0;
    foreach (pc[k]) pc[k] = 0;
    lowcnt = 0; first_idx = -1;
    for (int i = 1; i <= 22; i++) begin
      @(negedge clk);
      pv = {tstat_re, dma_re, dma_we, dat_re, dat_we, sbout_re, cmdin_we};
      for (int k = 0; k < 7; k++) pc[k] += pv[k];
      if (pv != 0 && first_idx < 0) first_idx = i;
      if (!sub_rst_n) lowcnt++;
      if (i == 2) rd_s = host_rdata;
      if (i == 4) begin hwr_n = 1; hrd_n = 1; end
    end
    dmack_n = 1; hen_n = 1;
  endtask

  function automatic int exp_idx(bit dm, bit hn, logic [1:0] ad, bit wr, bit xs);
    if (!dm) return wr ? 4 : 5;
    if (hn) return -1;
    if (ad == 0) return xs ? (wr ? 2 : 3) : (wr ? 0 : 1);
    if (ad == 1) return wr ? -1 : 6;
    return -1;
  endfunction

  function automatic string req_of(bit dm, bit hn, logic [1:0] ad, bit wr, bit xs);
    if (!dm) return "R1";
    if (hn) return "R2";
    if (ad == 0) return xs ? "R5" : "R4";
    if (ad == 1) return wr ? "R6" : "R7";
    return "R9";
  endfunction

  function automatic logic [7:0] exp_tstat(bit dma, bit ej, bit w, bit eop, bit st, bit xen);
    return {2'b11, ej, dma ? 1'b1 : w, eop, st, xen, dma ? w : 1'b0};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(sub_rst_n === 1 && dma_mode === 0 && dts_flag === 0, "R3 reset",
        {sub_rst_n, dma_mode, dts_flag}, 3'b100);
    chk({cmdin_we, sbout_re, dat_we, dat_re, dma_we, dma_re, tstat_re} === 0,
        "R2 reset pulses", 0, 0);

    // R10 latency
    @(negedge clk);
    dmack_n = 0; hwr_n = 0;
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      chk(dma_we === (i == 3), "R10 latency", dma_we, i == 3);
    end
    hwr_n = 1; dmack_n = 1;
    repeat (6) @(negedge clk);

    // R3 host-control load
    for (int v = 0; v < 4; v++) begin
      access(1, 0, 2, 1, 8'hFC | v[7:0]);
      chk({dts_flag, dma_mode} === v[1:0], "R3 hctl load", {dts_flag, dma_mode}, v);
    end

    // main sweep
    for (int h = 0; h < 4; h++) begin
      access(1, 0, 2, 1, h[7:0]);
      for (int x = 0; x < 2; x++) begin
        xfer_en_n = x[0];
        for (int c = 0; c < 32; c++) begin
          bit dm, hn, wr, xs; logic [1:0] ad; int ei; logic [7:0] er; bit bad;
          dm = c[4]; hn = c[3]; ad = c[2:1]; wr = c[0];
          xs = !h[0] && !x[0] && !h[1];
          access(dm, hn, ad, wr, h[7:0]);
          ei = exp_idx(dm, hn, ad, wr, xs);
          bad = 0;
          for (int k = 0; k < 7; k++) if (pc[k] != ((k == ei) ? 1 : 0)) bad = 1;
          if (ei >= 0 && first_idx != 3) bad = 1;
          chk(!bad, req_of(dm, hn, ad, wr, xs), first_idx * 256 + ei, ei);
          chk(lowcnt == ((dm && !hn && ad == 1 && wr) ? RSTC : 0), "R6 reset length",
              lowcnt, RSTC);
          chk({dts_flag, dma_mode} === h[1:0], "R6 hctl unchanged", {dts_flag, dma_mode}, h);
          if (!dm) er = 8'hA5;
          else if (hn) er = 8'hFF;
          else if (ad == 0) er = xs ? 8'hA5 : 8'h3C;
          else if (ad == 1) er = exp_tstat(h[0], 0, 0, 0, 0, x[0]);
          else er = 8'hFF;
          chk(rd_s === er, req_of(dm, hn, ad, wr, xs), rd_s, er);
        end
      end
    end

    // R7 / R8 status byte sweep
    for (int m = 0; m < 2; m++) begin
      access(1, 0, 2, 1, m[7:0]);
      dmack_n = 1; hen_n = 0; addr = 1;
      for (int p = 0; p < 32; p++) begin
        {eject_in, wait_src, eop_in, sten_in, xfer_en_n} = p[4:0];
        #1;
        chk(host_rdata === exp_tstat(m[0], p[4], p[3], p[2], p[1], p[0]), "R8 status byte",
            host_rdata, exp_tstat(m[0], p[4], p[3], p[2], p[1], p[0]));
      end
      hen_n = 1;
    end

    // R6 restart: two reset writes detected 6 clocks apart
    access(1, 0, 2, 1, 8'h00);
    @(negedge clk);
    dmack_n = 1; hen_n = 0; addr = 1; hwr_n = 0;
    lowcnt = 0;
    for (int i = 1; i <= 30; i++) begin
      @(negedge clk);
      if (!sub_rst_n) lowcnt++;
      if (i == 3) hwr_n = 1;
      if (i == 6) hwr_n = 0;
      if (i == 9) hwr_n = 1;
    end
    hen_n = 1;
    chk(lowcnt == 6 + RSTC, "R6 restart", lowcnt, 6 + RSTC);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule